// File: doc/BRIEF.md
# Asynchronous Memory Bank Strobe Sequencer

This block runs one access at a time to an external asynchronous memory that is split into four banks. A requester hands over a bank number, a read/write flag, an address and write data. The block then drives an active-low bank select, output enable, read strobe and write strobe. It counts each phase of the access in clock cycles and reports completion with a single-cycle response. For a read, the response carries the captured data.

Every bank has its own 16-bit timing word. The word sets the setup time (output enable before strobe), the strobe width for reads and for writes, the hold time (output enable after strobe), the idle gap used when a write follows a read, and optional wait-state stretching from a per-bank ready pin of programmable polarity. A 3-bit enable code limits which banks may be used. A request to a bank that is not enabled completes at once with an error.

The request side is a valid/ready handshake. The requester holds `req_valid` and its fields steady until `req_ready` is seen high at a clock edge. `req_ready` is high only while no access is in flight. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that the consumer must take in that cycle.

Top module: `amem_seq`

## Requirements
- R1: Out of reset, and at any time reset is asserted, `mem_oe_n`, `mem_rd_n`, `mem_wr_n` and every `mem_cs_n` bit are high, `rsp_valid` is low and `req_ready` is high. Reset also forgets a preceding read, so the first write after reset has no turnaround gap.
- R2: The bank-enable code works as follows. 000 enables no bank, 001 enables bank 0, 010 enables banks 0-1, 011 enables banks 0-2, and any code with bit 2 set enables all four banks.
- R3: A request to a disabled bank produces `rsp_valid` together with `rsp_err` in the cycle after acceptance. No select, output enable or strobe is asserted for that request.
- R4: Setup is taken from timing bits 5:4. Output enable and the bank select go low that many cycles before the strobe, and code 0 means 4 cycles.
- R5: The strobe is asserted for the read width (bits 11:8) on a read or the write width (bits 15:12) on a write. Code 0 counts as 1 cycle. Read and write strobes are never low together.
- R6: Hold is taken from bits 7:6. Output enable stays low for 0 to 3 cycles after the strobe rises.
- R7: A write whose previous completed access was a read starts with idle cycles set by bits 3:2 (code 0 means 4), in which all memory controls are high. Other orders start setup at once. Error completions do not change what counts as the previous access.
- R8: Bit 0 enables the ready pin of the bank and bit 1 selects its polarity (1 = active high, 0 = active low). When enabled, the strobe holds past its programmed width until ready is sampled active. When disabled, the pin has no effect.
- R9: Read data is sampled from `mem_rdata` at the clock edge that ends the last strobe cycle. It is presented on `rsp_rdata` with `rsp_valid`, which follows the hold phase by one cycle.
- R10: `mem_addr` and `mem_wdata` stay stable for the whole access. `mem_wdata_oe` is high from setup through hold on writes only. At most one `mem_cs_n` bit is low at any time.
- R11: `req_ready` is low from acceptance until the cycle after the response. `rsp_valid` lasts one cycle. While `req_ready` is high, all memory controls are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_cfg | input | 64 | Four 16-bit timing words, bank n at bits 16n+15:16n |
| bank_en_code | input | 3 | Bank enable code |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_bank | input | 2 | Target bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was refused (disabled bank) |
| rsp_rdata | output | 16 | Captured read data |
| mem_cs_n | output | 4 | Bank selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | 20 | Address to memory |
| mem_wdata | output | 16 | Write data to memory |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | 16 | Read data from memory |
| mem_ready | input | 4 | Per-bank ready pins |

## Verification
The assertions assume three things about the inputs. The timing words and the enable code do not change while an access is in flight. Request fields are held until acceptance. Ready pins are synchronous to `clk`. The bench writes a bank's timing word and the enable code only while the block is idle and before raising `req_valid`. It drops `req_valid` on the falling edge right after acceptance. It moves the ready pins only on falling clock edges.

// File: rtl/amem_pkg.sv
`timescale 1ns/1ps
package amem_pkg;
  localparam int CFG_W = 16;
  localparam int CNT_W = 4;
  localparam int EN_W  = 3;

  // timing word layout (msb first)
  typedef struct packed {
    logic [3:0] wr_acc;
    logic [3:0] rd_acc;
    logic [1:0] hold;
    logic [1:0] setup;
    logic [1:0] turn;
    logic       rdy_pol;
    logic       rdy_en;
  } bank_cfg_t;

  // decoded cycle counts
  typedef struct packed {
    logic [CNT_W-1:0] turn_cyc;
    logic [CNT_W-1:0] setup_cyc;
    logic [CNT_W-1:0] rd_cyc;
    logic [CNT_W-1:0] wr_cyc;
    logic [CNT_W-1:0] hold_cyc;
    logic             rdy_en;
    logic             rdy_pol;
  } bank_tim_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_SETUP, PH_STROBE, PH_HOLD, PH_DONE
  } phase_t;

  // two-bit code where zero stands for four cycles
  function automatic logic [CNT_W-1:0] zero_is_four(input logic [1:0] c);
    return (c == 2'd0) ? CNT_W'(4) : CNT_W'(c);
  endfunction

  // four-bit width where zero is promoted to one cycle
  function automatic logic [CNT_W-1:0] at_least_one(input logic [3:0] c);
    return (c == 4'd0) ? CNT_W'(1) : CNT_W'(c);
  endfunction
endpackage

// File: rtl/amem_cfg_decode.sv
`timescale 1ns/1ps
module amem_cfg_decode
  import amem_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic [NBANK*CFG_W-1:0] cfg_flat,
  output bank_tim_t [NBANK-1:0]  tim
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_cfg_t raw;
    assign raw = bank_cfg_t'(cfg_flat[b*CFG_W +: CFG_W]);
    assign tim[b].turn_cyc  = zero_is_four(raw.turn);
    assign tim[b].setup_cyc = zero_is_four(raw.setup);
    assign tim[b].rd_cyc    = at_least_one(raw.rd_acc);
    assign tim[b].wr_cyc    = at_least_one(raw.wr_acc);
    assign tim[b].hold_cyc  = CNT_W'(raw.hold);
    assign tim[b].rdy_en    = raw.rdy_en;
    assign tim[b].rdy_pol   = raw.rdy_pol;
  end
endmodule

// File: rtl/amem_bank_gate.sv
`timescale 1ns/1ps
module amem_bank_gate
  import amem_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic [EN_W-1:0]  en_code,
  output logic [NBANK-1:0] en_mask
);
  // top code bit opens every bank; otherwise the low bits give a bank count
  for (genvar b = 0; b < NBANK; b++) begin : g_gate
    assign en_mask[b] = en_code[EN_W-1] || (b < int'(en_code[EN_W-2:0]));
  end
endmodule

// File: rtl/amem_phase_ctrl.sv
`timescale 1ns/1ps
module amem_phase_ctrl
  import amem_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      start_err,
  input  logic      start_turn,
  input  logic      is_write,
  input  logic      rdy_pin,
  input  bank_tim_t tim,
  output phase_t    phase,
  output logic      strobe_last
);
  logic [CNT_W-1:0] cnt, cnt_nxt;
  phase_t           nxt;
  logic             rdy_ok;
  logic             cnt_one;
  logic [CNT_W-1:0] acc_len;

  assign cnt_one     = (cnt == CNT_W'(1));
  assign rdy_ok      = !tim.rdy_en || (tim.rdy_pol ? rdy_pin : !rdy_pin);
  assign acc_len     = is_write ? tim.wr_cyc : tim.rd_cyc;
  assign strobe_last = (phase == PH_STROBE) && cnt_one && rdy_ok;

  always_comb begin
    nxt     = phase;
    cnt_nxt = (cnt > CNT_W'(1)) ? cnt - CNT_W'(1) : cnt;
    unique case (phase)
      PH_IDLE: if (start) begin
        if (start_err) begin
          nxt = PH_DONE;
        end else if (start_turn) begin
          nxt = PH_TURN;  cnt_nxt = tim.turn_cyc;
        end else begin
          nxt = PH_SETUP; cnt_nxt = tim.setup_cyc;
        end
      end
      PH_TURN:  if (cnt_one) begin nxt = PH_SETUP;  cnt_nxt = tim.setup_cyc; end
      PH_SETUP: if (cnt_one) begin nxt = PH_STROBE; cnt_nxt = acc_len; end
      PH_STROBE: if (strobe_last) begin
        if (tim.hold_cyc == '0) nxt = PH_DONE;
        else begin nxt = PH_HOLD; cnt_nxt = tim.hold_cyc; end
      end
      PH_HOLD:  if (cnt_one) nxt = PH_DONE;
      PH_DONE:  nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= nxt;
      cnt   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/amem_seq.sv
`timescale 1ns/1ps
module amem_seq
  import amem_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 20,
  parameter int DW    = 16,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBANK*CFG_W-1:0] bank_cfg,
  input  logic [EN_W-1:0]        bank_en_code,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [BW-1:0]          req_bank,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [DW-1:0]          rsp_rdata,
  output logic [NBANK-1:0]       mem_cs_n,
  output logic                   mem_oe_n,
  output logic                   mem_rd_n,
  output logic                   mem_wr_n,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  output logic                   mem_wdata_oe,
  input  logic [DW-1:0]          mem_rdata,
  input  logic [NBANK-1:0]       mem_ready
);
  bank_tim_t [NBANK-1:0] tim_all;
  logic [NBANK-1:0]      en_mask;
  phase_t                phase;
  logic                  strobe_last;
  logic                  accept;
  logic [BW-1:0]         bank_q, sel_bank;
  logic                  wr_q, err_q, last_rd;
  logic [AW-1:0]         addr_q;
  logic [DW-1:0]         wdata_q, rdata_q;
  logic                  bus_on;

  amem_cfg_decode #(.NBANK(NBANK)) i_dec (
    .cfg_flat (bank_cfg),
    .tim      (tim_all)
  );

  amem_bank_gate #(.NBANK(NBANK)) i_gate (
    .en_code (bank_en_code),
    .en_mask (en_mask)
  );

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign sel_bank  = req_ready ? req_bank : bank_q;

  amem_phase_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_err   (!en_mask[req_bank]),
    .start_turn  (req_write && last_rd),
    .is_write    (wr_q),
    .rdy_pin     (mem_ready[sel_bank]),
    .tim         (tim_all[sel_bank]),
    .phase       (phase),
    .strobe_last (strobe_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      last_rd <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        bank_q  <= req_bank;
        wr_q    <= req_write;
        err_q   <= !en_mask[req_bank];
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (strobe_last && !wr_q) rdata_q <= mem_rdata;
      if (phase == PH_DONE && !err_q) last_rd <= !wr_q;
    end
  end

  assign bus_on       = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign mem_oe_n     = !bus_on;
  assign mem_rd_n     = !((phase == PH_STROBE) && !wr_q);
  assign mem_wr_n     = !((phase == PH_STROBE) && wr_q);
  assign mem_wdata_oe = bus_on && wr_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign mem_cs_n[b] = !(bus_on && (bank_q == BW'(b)));
  end

  assign rsp_valid = (phase == PH_DONE);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/amem_seq_chk.sv
`timescale 1ns/1ps
module amem_seq_chk #(
  parameter int NBANK = 4,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [NBANK-1:0] mem_cs_n,
  input logic             mem_oe_n,
  input logic             mem_rd_n,
  input logic             mem_wr_n,
  input logic [DW-1:0]    mem_wdata,
  input logic             mem_wdata_oe
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n)); // R5
  AST_SETUP_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_rd_n) || $fell(mem_wr_n)) |-> $past(!mem_oe_n)); // R4
  AST_ERR_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && $past(req_valid && req_ready) && mem_oe_n)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_oe_n && mem_rd_n && mem_wr_n && (&mem_cs_n))); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wdata_oe && $past(mem_wdata_oe)) |-> $stable(mem_wdata)); // R10
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R10
endmodule

bind amem_seq amem_seq_chk #(.NBANK(NBANK), .DW(DW)) i_amem_seq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .mem_cs_n     (mem_cs_n),
  .mem_oe_n     (mem_oe_n),
  .mem_rd_n     (mem_rd_n),
  .mem_wr_n     (mem_wr_n),
  .mem_wdata    (mem_wdata),
  .mem_wdata_oe (mem_wdata_oe)
);

// File: tb/test_amem_seq.sv
`timescale 1ns/1ps
module test_amem_seq;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] bank_cfg = '0;
  logic [2:0]  bank_en_code = 3'b100;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_rd_n, mem_wr_n, mem_wdata_oe;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0BAD;
  logic [3:0]  mem_ready = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  amem_seq i_amem_seq (
    .clk(clk), .rst_n(rst_n), .bank_cfg(bank_cfg), .bank_en_code(bank_en_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  typedef struct packed {
    logic [2:0]  en;
    logic [1:0]  bank;
    logic        wr;
    logic [15:0] cfg;
    logic [3:0]  rdy_after;
    logic        x_err;
    logic [3:0]  x_turn;
    logic [3:0]  x_setup;
    logic [3:0]  x_strobe;
    logic [3:0]  x_hold;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'b100, 2'd0, 1'b0, 16'h3250, 4'd0, 1'b0, 4'd0, 4'd1, 4'd2,  4'd1},
    '{3'b100, 2'd0, 1'b1, 16'h3250, 4'd0, 1'b0, 4'd4, 4'd1, 4'd3,  4'd1},
    '{3'b100, 2'd1, 1'b0, 16'h0004, 4'd0, 1'b0, 4'd0, 4'd4, 4'd1,  4'd0},
    '{3'b100, 2'd1, 1'b1, 16'h0004, 4'd0, 1'b0, 4'd1, 4'd4, 4'd1,  4'd0},
    '{3'b100, 2'd2, 1'b1, 16'hF1F8, 4'd0, 1'b0, 4'd0, 4'd3, 4'd15, 4'd3},
    '{3'b100, 2'd2, 1'b0, 16'hF1F8, 4'd0, 1'b0, 4'd0, 4'd3, 4'd1,  4'd3},
    '{3'b100, 2'd3, 1'b1, 16'h45AC, 4'd0, 1'b0, 4'd3, 4'd2, 4'd4,  4'd2},
    '{3'b100, 2'd3, 1'b0, 16'h1213, 4'd6, 1'b0, 4'd0, 4'd1, 4'd6,  4'd0},
    '{3'b100, 2'd3, 1'b0, 16'h1311, 4'd0, 1'b0, 4'd0, 4'd1, 4'd3,  4'd0},
    '{3'b100, 2'd0, 1'b0, 16'h1413, 4'd2, 1'b0, 4'd0, 4'd1, 4'd4,  4'd0},
    '{3'b100, 2'd1, 1'b0, 16'h1310, 4'd9, 1'b0, 4'd0, 4'd1, 4'd3,  4'd0},
    '{3'b010, 2'd2, 1'b0, 16'h1110, 4'd0, 1'b1, 4'd0, 4'd0, 4'd0,  4'd0},
    '{3'b011, 2'd2, 1'b0, 16'h1110, 4'd0, 1'b0, 4'd0, 4'd1, 4'd1,  4'd0},
    '{3'b011, 2'd3, 1'b1, 16'h1110, 4'd0, 1'b1, 4'd0, 4'd0, 4'd0,  4'd0},
    '{3'b001, 2'd1, 1'b0, 16'h1110, 4'd0, 1'b1, 4'd0, 4'd0, 4'd0,  4'd0},
    '{3'b001, 2'd0, 1'b1, 16'h2150, 4'd0, 1'b0, 4'd4, 4'd1, 4'd2,  4'd1},
    '{3'b000, 2'd0, 1'b0, 16'h2150, 4'd0, 1'b1, 4'd0, 4'd0, 4'd0,  4'd0},
    '{3'b111, 2'd3, 1'b0, 16'h1110, 4'd0, 1'b0, 4'd0, 4'd1, 4'd1,  4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one access, measured phase by phase at falling edges
  task automatic run_vec(input vec_t v, input int idx);
    int gap = 0, setup = 0, strb = 0, hold = 0, guard = 0;
    bit seen = 1'b0, wbad = 1'b0, rbusy = 1'b0, got_err = 1'b0;
    logic [15:0] got_data = '0;
    logic [15:0] rd_word = {idx[7:0], 8'hC3};
    logic act_lvl = v.cfg[1];
    bank_en_code = v.en;
    bank_cfg[v.bank*16 +: 16] = v.cfg;
    mem_ready[v.bank] = (v.rdy_after == 0) ? act_lvl : ~act_lvl;
    req_bank  = v.bank;
    req_write = v.wr;
    req_addr  = 20'h100 + 20'(idx * 37);
    req_wdata = 16'h1000 + 16'(idx * 13);
    chk(req_ready, "R11 ready while idle", int'(req_ready), 1);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && guard < 100) begin
      guard++;
      if (req_ready) rbusy = 1'b1;
      if (mem_oe_n) begin
        gap++;
        if (!mem_rd_n || !mem_wr_n || !(&mem_cs_n)) wbad = 1'b1;
      end else if (!mem_rd_n || !mem_wr_n) begin
        strb++; seen = 1'b1;
        if (v.wr && (mem_wdata != req_wdata || !mem_wdata_oe)) wbad = 1'b1;
        if (mem_addr != req_addr || mem_cs_n[v.bank]) wbad = 1'b1;
        if (strb == int'(v.rdy_after)) mem_ready[v.bank] = act_lvl;
        mem_rdata = (strb == int'(v.x_strobe)) ? rd_word : (16'h0BAD ^ 16'(strb));
      end else if (!seen) begin
        setup++;
      end else begin
        hold++;
        if (v.wr && (mem_wdata != req_wdata || !mem_wdata_oe)) wbad = 1'b1;
      end
      @(negedge clk);
    end
    got_err  = rsp_err;
    got_data = rsp_rdata;
    chk(rsp_valid, $sformatf("R11 vec%0d response seen", idx), int'(rsp_valid), 1);
    chk(got_err == v.x_err, $sformatf("R3 R2 vec%0d error flag", idx), int'(got_err), int'(v.x_err));
    chk(gap == int'(v.x_turn), $sformatf("R7 vec%0d turnaround", idx), gap, int'(v.x_turn));
    chk(setup == int'(v.x_setup), $sformatf("R4 vec%0d setup", idx), setup, int'(v.x_setup));
    chk(strb == int'(v.x_strobe), $sformatf("R5 R8 vec%0d strobe", idx), strb, int'(v.x_strobe));
    chk(hold == int'(v.x_hold), $sformatf("R6 vec%0d hold", idx), hold, int'(v.x_hold));
    chk(!wbad, $sformatf("R10 vec%0d bus held", idx), int'(wbad), 0);
    chk(!rbusy, $sformatf("R11 vec%0d busy during access", idx), int'(rbusy), 0);
    if (!v.wr && !v.x_err)
      chk(got_data == rd_word, $sformatf("R9 vec%0d read data", idx), int'(got_data), int'(rd_word));
    @(negedge clk);
    chk(!rsp_valid && req_ready, $sformatf("R11 vec%0d pulse ends", idx), int'(rsp_valid), 0);
    mem_ready = '0;
    mem_rdata = 16'h0BAD;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state under reset
    chk(mem_oe_n && mem_rd_n && mem_wr_n && (&mem_cs_n), "R1 controls high in reset",
        int'({mem_oe_n, mem_rd_n, mem_wr_n}), 7);
    chk(!rsp_valid && req_ready, "R1 handshake in reset", int'({rsp_valid, req_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_oe_n && (&mem_cs_n) && req_ready, "R1 idle after reset", int'(mem_oe_n), 1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1: reset in mid-strobe returns controls high and forgets the read
    bank_en_code = 3'b100;
    bank_cfg[15:0] = 16'h2F50;
    req_bank = 2'd0; req_write = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(!mem_rd_n, "R5 long strobe active", int'(mem_rd_n), 0);
    rst_n = 1'b0;
    #1;
    chk(mem_oe_n && mem_rd_n && (&mem_cs_n) && req_ready, "R1 reset mid-access",
        int'({mem_oe_n, mem_rd_n}), 3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec('{3'b100, 2'd0, 1'b1, 16'h2150, 4'd0, 1'b0, 4'd0, 4'd1, 4'd2, 4'd1}, 40);

    summary();
  end
endmodule